// File: doc/BRIEF.md
# Five-Phase Multicycle Byte Processor

This block is a small programmable processor core that runs a program held in an external program memory and works on an external data memory. Each instruction is one 16-bit word. The high byte holds a 4-bit operation code and a 4-bit register number. The low byte holds a direct address, a second register number, an immediate value or a branch offset. The core has sixteen 8-bit registers. It can load from and store to data memory, store through a register pointer, load an immediate value, add, subtract, and branch on a zero register.

Every instruction takes exactly five clock cycles, in this order: fetch, decode, operand fetch, execute, result store. A phase that the instruction does not need still uses its cycle. Both memories are synchronous and read with one cycle of latency: the address presented before a clock edge returns its data after that edge. A stop code raises a sticky halt flag and parks the core, so a testbench can see when a program has ended.

Top module: `nib_core`

## Requirements
- R1: While `rst` is high, on each clock edge the program counter is cleared to 0, all sixteen registers are cleared to 0, `halted` is cleared, and the core is placed in the fetch phase. The first instruction fetched after reset comes from address 0.
- R2: Each instruction takes five cycles, in this order: fetch, decode, operand fetch, execute, store. The program counter, seen on `dbg_pc`, increases by one on the clock edge that ends fetch. So the next instruction is fetched five cycles after the current one.
- R3: Instruction fields are as follows. Bits [15:12] are the operation code. Bits [11:8] are register Rn. Bits [7:0] are the byte operand. When a second register Rm is used, it is bits [7:4].
- R4: Code 0000 loads Rn from data memory at the byte operand. Code 0011 loads the byte operand itself into Rn.
- R5: Code 0001 writes Rn to data memory at the byte operand. It does this with a single one-cycle `dmem_we` pulse in the store phase. `dmem_we` is never high in any other phase.
- R6: Code 0010 writes Rm to the data memory address held in Rn.
- R7: Code 0100 sets Rn to Rn+Rm, and code 0101 sets Rn to Rn−Rm. Both wrap modulo 256.
- R8: Code 0110 adds the byte operand, read as two's complement, to the address of the next instruction. It does this only when Rn is zero. Otherwise execution goes on to the next instruction.
- R9: Codes 0111 to 1110 change no register and write no memory. They still take five cycles.
- R10: Code 1111 sets `halted` at the end of its decode phase. `halted` then stays high until reset. After that the program counter no longer changes and no data memory write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Program memory word address |
| imem_rdata | input | 16 | Program memory read data, one cycle after address |
| dmem_addr | output | 8 | Data memory address for reads and writes |
| dmem_rdata | input | 8 | Data memory read data, one cycle after address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 8 | Data memory write data |
| halted | output | 1 | Sticky stop flag |
| dbg_pc | output | 8 | Current program counter |

## Verification
The register file is hidden. A wrong register value is therefore only seen when a later store puts it on `dmem_wdata`, or when a branch on that register takes the wrong path. That is at least five cycles later, and often a whole loop later. The test programs therefore store each result right after computing it, and they run a counting loop whose final sum depends on every add, subtract and branch decision. A wrong phase sequence or program counter step is seen sooner: it shows on `dbg_pc` within one instruction, and the bench checks `dbg_pc` and `halted` cycle by cycle around the fetch and decode edges.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int NREG  = 16;
    localparam int RIW   = $clog2(NREG);
    localparam int IW    = 16;

    typedef enum logic [3:0] {
        OP_LDD  = 4'b0000,
        OP_STD  = 4'b0001,
        OP_STI  = 4'b0010,
        OP_LDI  = 4'b0011,
        OP_ADD  = 4'b0100,
        OP_SUB  = 4'b0101,
        OP_BRZ  = 4'b0110,
        OP_STOP = 4'b1111
    } opcode_e;

    typedef enum logic [2:0] {
        PH_FETCH = 3'd0,
        PH_DEC   = 3'd1,
        PH_OPND  = 3'd2,
        PH_EXEC  = 3'd3,
        PH_STORE = 3'd4
    } phase_e;

    typedef struct packed {
        logic [3:0]     op;
        logic [RIW-1:0] rn;
        logic [7:0]     arg;
    } instr_t;

    function automatic logic [AW-1:0] sext_off(input logic [7:0] off);
        return AW'($signed(off));
    endfunction

    function automatic logic writes_reg(input logic [3:0] op);
        return (op == OP_LDD) || (op == OP_LDI) || (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/nib_regfile.sv
module nib_regfile #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int IXW  = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [IXW-1:0] ra,
    input  logic [IXW-1:0] rb,
    output logic [W-1:0]   qa,
    output logic [W-1:0]   qb,
    input  logic           we,
    input  logic [IXW-1:0] wa,
    input  logic [W-1:0]   wd
);
    logic [W-1:0] regs [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (we && (wa == IXW'(g)))
                    regs[g] <= wd;
            end
        end
    endgenerate

    assign qa = regs[ra];
    assign qb = regs[rb];
endmodule

// File: rtl/nib_alu.sv
module nib_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    always_comb begin
        if (sub)
            y = a - b;
        else
            y = a + b;
    end
endmodule

// File: rtl/nib_seq.sv
module nib_seq
    import nib_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   park,
    output phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_FETCH;
        else begin
            unique case (phase)
                PH_FETCH: phase <= PH_DEC;
                PH_DEC:   phase <= PH_OPND;
                PH_OPND:  phase <= PH_EXEC;
                PH_EXEC:  phase <= PH_STORE;
                PH_STORE: phase <= park ? PH_STORE : PH_FETCH;
                default:  phase <= PH_FETCH;
            endcase
        end
    end

    // R2
    dec_to_opnd_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DEC) |=> (phase == PH_OPND));

    // R2
    exec_to_store_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |=> (phase == PH_STORE));
endmodule

// File: rtl/nib_core.sv
module nib_core
    import nib_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] imem_addr,
    input  logic [IW-1:0] imem_rdata,
    output logic [AW-1:0] dmem_addr,
    input  logic [DW-1:0] dmem_rdata,
    output logic          dmem_we,
    output logic [DW-1:0] dmem_wdata,
    output logic          halted,
    output logic [AW-1:0] dbg_pc
);
    phase_e        phase;
    instr_t        ir;
    logic [AW-1:0] pc;
    logic [DW-1:0] opa, opb, res;
    logic [DW-1:0] rf_qa, rf_qb, alu_y;
    logic          rf_we;

    nib_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .park  (halted),
        .phase (phase)
    );

    nib_regfile #(.W(DW), .DEPTH(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra  (ir.rn),
        .rb  (ir.arg[7:4]),
        .qa  (rf_qa),
        .qb  (rf_qb),
        .we  (rf_we),
        .wa  (ir.rn),
        .wd  (res)
    );

    nib_alu #(.W(DW)) u_alu (
        .a   (opa),
        .b   (opb),
        .sub (ir.op == OP_SUB),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            opa    <= '0;
            opb    <= '0;
            res    <= '0;
            halted <= 1'b0;
        end else begin
            unique case (phase)
                PH_FETCH: begin
                    ir <= instr_t'(imem_rdata);
                    pc <= pc + AW'(1);
                end
                PH_DEC: begin
                    if (ir.op == OP_STOP)
                        halted <= 1'b1;
                end
                PH_OPND: begin
                    opa <= rf_qa;
                    if (ir.op == OP_LDD)
                        opb <= dmem_rdata;
                    else if (ir.op == OP_LDI)
                        opb <= ir.arg;
                    else
                        opb <= rf_qb;
                end
                PH_EXEC: begin
                    if ((ir.op == OP_ADD) || (ir.op == OP_SUB))
                        res <= alu_y;
                    else
                        res <= opb;
                    if ((ir.op == OP_BRZ) && (opa == '0))
                        pc <= pc + sext_off(ir.arg);
                end
                default: ;
            endcase
        end
    end

    assign rf_we      = (phase == PH_STORE) && writes_reg(ir.op) && !halted;
    assign dmem_we    = (phase == PH_STORE) && !halted &&
                        ((ir.op == OP_STD) || (ir.op == OP_STI));
    assign dmem_addr  = ((phase == PH_STORE) && (ir.op == OP_STI)) ? opa : ir.arg;
    assign dmem_wdata = (ir.op == OP_STI) ? opb : opa;
    assign imem_addr  = pc;
    assign dbg_pc     = pc;

    // R2
    fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (pc == AW'($past(pc) + AW'(1))));

    // R5
    we_in_store_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (phase == PH_STORE));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc) && !dmem_we));
endmodule

// File: tb/nib_core_tb.sv
`timescale 1ns/1ps
module nib_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr, dmem_addr, dmem_wdata, dbg_pc;
    logic [15:0] imem_q;
    logic [7:0]  dmem_q;
    logic        dmem_we, halted;

    logic [15:0] imem [256];
    logic [7:0]  dmem [256];
    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    nib_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_q),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_q),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .halted     (halted),
        .dbg_pc     (dbg_pc)
    );

    always @(posedge clk) begin
        cyc    <= cyc + 1;
        imem_q <= imem[imem_addr];
        dmem_q <= dmem[dmem_addr];
        if (dmem_we && !rst) begin
            dmem[dmem_addr] <= dmem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog: actual cycles=%0d expected halt earlier", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 16'hF000;
            dmem[i] = 8'hEE;
        end
    endtask

    task automatic start();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        wr_cnt = 0;
        rst = 1'b0;
    endtask

    task automatic run_to_halt();
        start();
        for (int n = 0; n < 3000 && !halted; n++) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pc after reset", dbg_pc, 0);
        chk("R1 halted after reset", halted, 0);
        chk("R1 no write in reset", dmem_we, 0);
    endtask

    task automatic t_timing();
        clear_mem();
        imem[0] = 16'h7000;
        imem[1] = 16'hF000;
        start();
        @(negedge clk);
        chk("R2 pc after first fetch", dbg_pc, 1);
        repeat (4) @(negedge clk);
        chk("R2 pc held through phases", dbg_pc, 1);
        @(negedge clk);
        chk("R2 pc after second fetch", dbg_pc, 2);
        chk("R10 halted before decode", halted, 0);
        @(negedge clk);
        chk("R10 halted after decode", halted, 1);
        repeat (20) @(negedge clk);
        chk("R10 pc frozen", dbg_pc, 2);
        chk("R9 nop wrote nothing", wr_cnt, 0);
    endtask

    task automatic t_sum_loop();
        clear_mem();
        imem[0] = 16'h3000; imem[1] = 16'h310A; imem[2] = 16'h3201;
        imem[3] = 16'h3300; imem[4] = 16'h6103; imem[5] = 16'h4010;
        imem[6] = 16'h5120; imem[7] = 16'h63FC; imem[8] = 16'h1040;
        imem[9] = 16'hF000;
        run_to_halt();
        chk("R8 loop sum 10..1", dmem[8'h40], 55);
        chk("R10 halt pc", dbg_pc, 10);
        chk("R5 one write", wr_cnt, 1);
    endtask

    task automatic t_load_store();
        clear_mem();
        dmem[8'h10] = 8'hAB;
        imem[0] = 16'h0510; imem[1] = 16'h3720; imem[2] = 16'h2750;
        imem[3] = 16'h1521; imem[4] = 16'hF000;
        run_to_halt();
        chk("R6 indirect store", dmem[8'h20], 8'hAB);
        chk("R4 R5 direct load then store", dmem[8'h21], 8'hAB);
        chk("R3 R5 write count", wr_cnt, 2);
    endtask

    task automatic t_arith();
        clear_mem();
        imem[0] = 16'h38F0; imem[1] = 16'h3920; imem[2] = 16'h4890;
        imem[3] = 16'h1830; imem[4] = 16'h3A05; imem[5] = 16'h3B07;
        imem[6] = 16'h5AB0; imem[7] = 16'h1A31; imem[8] = 16'hF000;
        run_to_halt();
        chk("R7 add wraps", dmem[8'h30], 8'h10);
        chk("R7 sub wraps", dmem[8'h31], 8'hFE);
    endtask

    task automatic t_nops();
        clear_mem();
        imem[0] = 16'h3C55; imem[1] = 16'h7C00; imem[2] = 16'h8CFF;
        imem[3] = 16'hEC23; imem[4] = 16'h1C50; imem[5] = 16'hF000;
        run_to_halt();
        chk("R9 nops leave register", dmem[8'h50], 8'h55);
        chk("R9 nops write nothing", wr_cnt, 1);
        chk("R9 nop untouched addr", dmem[8'hFF], 8'hEE);
    endtask

    task automatic t_branch();
        clear_mem();
        imem[0] = 16'h3D01; imem[1] = 16'h6D02; imem[2] = 16'h1D60;
        imem[3] = 16'h3E00; imem[4] = 16'h6E01; imem[5] = 16'h1D61;
        imem[6] = 16'h1E62; imem[7] = 16'hF000;
        run_to_halt();
        chk("R8 not taken falls through", dmem[8'h60], 1);
        chk("R8 taken skips", dmem[8'h61], 8'hEE);
        chk("R8 target reached", dmem[8'h62], 0);
    endtask

    task automatic t_reset_regs();
        clear_mem();
        imem[0] = 16'h1570; imem[1] = 16'h1C71; imem[2] = 16'hF000;
        run_to_halt();
        chk("R1 regs cleared by reset", dmem[8'h70], 0);
        chk("R1 regs cleared by reset C", dmem[8'h71], 0);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_sum_loop();
        t_load_store();
        t_arith();
        t_nops();
        t_branch();
        t_reset_regs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule